// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Source/Destination Filter

This block takes one differential avionics data pair (an A leg and a B leg), recovers 32-bit words from the return-to-null bit cells, and places the words that pass its filters into a receive FIFO. A bit is signalled by one leg going high while the other stays low. Each bit is followed by a null half-cell, and words are separated by a longer null gap. The receiver counts the bits of each word and times the null gap that ends it. The first eight bits arrive most significant first, so it turns them round into a label byte in word bits 7..0. The remaining 24 bits are kept in arrival order.

At the end of each word the block can apply three filters. The first checks bit 31 as odd or even parity. The second compares the two source/destination bits against programmed values. The third asks an external label lookup whether the label is wanted. The label is presented on an output for one cycle and the lookup answers combinationally in that same cycle. A host reaches the block through a 2-bit register select: data (pop), control, status and a reserved code. The interrupt is high while any FIFO status flag is set.

Top module: `arinc_rx`

## Requirements
- R1: Word bits 7..0 hold the first eight received bits in reverse order: the first bit lands in bit 7 and the eighth in bit 0. Received bits 9 to 32 land in word bits 8..31 in arrival order.
- R2: A word is pushed only if exactly 32 bits arrive before a null run of at least 4 bit times. A word with fewer bits or with more bits (two words separated by too short a gap count as one) is discarded.
- R3: Control bit 0 = 0 sets a bit time of CLK_MHZ*10 cycles (100 kbit/s). Control bit 0 = 1 sets the slow bit time (CLK_MHZ*80 cycles, or CLK_MHZ*20 when SLOW_50 = 1). The gap limit is 4 bit times at the selected rate.
- R4: With control bit 2 set, a word is kept only if its count of ones is odd (control bit 3 = 0) or even (control bit 3 = 1). With control bit 2 clear, word bit 31 is stored as plain data.
- R5: With control bit 4 set, a word is kept only if word bit 8 equals control bit 5 and word bit 9 equals control bit 6.
- R6: With control bit 1 set, a word is kept only if label_hit_i is high in the cycle lbl_vld_o is high; lbl_o then carries word bits 7..0. With control bit 1 clear, label_hit_i is ignored.
- R7: A status read returns bit 0 = FIFO empty, bit 1 = occupancy at or above LEVEL, and bit 2 = FIFO full. The other bits read as zero. irq_o is high while any of these three flags is high.
- R8: When the FIFO is full, an accepted word is dropped and the stored words are kept unchanged.
- R9: A data read pops the oldest word, which appears on rdata_o the cycle after rd_en_i. A data read from an empty FIFO returns the last word popped (zero after reset) and changes nothing.
- R10: reg_sel_i selects the register: 00 = data, 01 = control, 10 = status, 11 = reads zero. The control register resets to zero and is written with wdata_i when wr_en_i is high. Its bit 7 always reads zero.
- R11: A leg A high with leg B low is a 1, leg A low with leg B high is a 0, and equal legs are null. Each change from null to a driven state marks one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (CLK_MHZ) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_a_i | input | 1 | Line leg A |
| line_b_i | input | 1 | Line leg B |
| reg_sel_i | input | 2 | Register select |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Control write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| lbl_o | output | 8 | Label of the word under decision |
| lbl_vld_o | output | 1 | lbl_o is valid; label_hit_i is sampled |
| label_hit_i | input | 1 | External label lookup result |
| irq_o | output | 1 | Interrupt: any FIFO flag set |

## Verification
The assertions assume that the control register does not change while a word is on the line. They also assume that each bit cell is a clean driven half followed by a null half, with no extra transitions inside a cell. The bench writes control only while the line is idle, after the gap of the previous word has run out. It drives every cell as exact half-bit pulses, with explicit gaps shorter or longer than the limit. The label lookup is modelled as a combinational table indexed by lbl_o, so label_hit_i always answers in the cycle the label is presented.

// File: rtl/arinc_rx_pkg.sv
package arinc_rx_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_CTRL = 2'b01,
    SEL_STAT = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic spare;
    logic sdi_b10;
    logic sdi_b9;
    logic sdi_en;
    logic par_even;
    logic par_en;
    logic lbl_en;
    logic slow;
  } ctrl_t;

  // arrival order -> word order: label byte reversed, rest in place
  function automatic logic [31:0] map_word(input logic [31:0] arr);
    logic [31:0] r;
    r[31:8] = arr[31:8];
    for (int i = 0; i < 8; i++) r[i] = arr[7-i];
    return r;
  endfunction

endpackage

// File: rtl/arinc_rx_line.sv
module arinc_rx_line #(
  parameter int CLK_MHZ = 10,
  parameter bit SLOW_50 = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        a_i,
  input  logic        b_i,
  input  logic        slow_i,
  output logic        word_v_o,
  output logic [31:0] word_o
);
  import arinc_rx_pkg::*;

  localparam int FAST_CYC = CLK_MHZ * 10;
  localparam int SLOW_CYC = SLOW_50 ? CLK_MHZ * 20 : CLK_MHZ * 80;
  localparam int GAP_FAST = 4 * FAST_CYC;
  localparam int GAP_SLOW = 4 * SLOW_CYC;
  localparam int GW       = $clog2(GAP_SLOW + 1);

  logic [1:0]    a_s, b_s;
  logic          a_q, b_q, active, prev_act, rise;
  logic [5:0]    bit_cnt;
  logic [31:0]   sr;
  logic [GW-1:0] gap_cnt, gap_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_s <= '0;
      b_s <= '0;
    end else begin
      a_s <= {a_s[0], a_i};
      b_s <= {b_s[0], b_i};
    end
  end

  assign a_q     = a_s[1];
  assign b_q     = b_s[1];
  assign active  = a_q ^ b_q;
  assign rise    = active & ~prev_act;
  assign gap_lim = slow_i ? GW'(GAP_SLOW - 1) : GW'(GAP_FAST - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_act <= 1'b0;
      bit_cnt  <= '0;
      gap_cnt  <= '0;
      sr       <= '0;
      word_v_o <= 1'b0;
      word_o   <= '0;
    end else begin
      prev_act <= active;
      word_v_o <= 1'b0;
      if (rise) begin
        if (bit_cnt < 6'd32) sr[bit_cnt[4:0]] <= a_q;
        if (bit_cnt != 6'd33) bit_cnt <= bit_cnt + 6'd1;  // 33 = too many
        gap_cnt <= '0;
      end else if (active) begin
        gap_cnt <= '0;
      end else if (bit_cnt != 6'd0) begin
        if (gap_cnt >= gap_lim) begin
          word_v_o <= (bit_cnt == 6'd32);
          word_o   <= map_word(sr);
          bit_cnt  <= '0;
          gap_cnt  <= '0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end
    end
  end

  a_r2_word_after_null: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_v_o |-> !$past(active));

  a_r2_count_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_v_o |-> (bit_cnt == 6'd0));

  a_r11_one_bit_per_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && bit_cnt < 6'd33) |=> (bit_cnt == $past(bit_cnt) + 6'd1));

endmodule

// File: rtl/arinc_rx_filter.sv
module arinc_rx_filter (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                word_v_i,
  input  logic [31:0]         word_i,
  input  arinc_rx_pkg::ctrl_t ctrl_i,
  input  logic                label_hit_i,
  output logic [7:0]          lbl_o,
  output logic                lbl_vld_o,
  output logic                push_o,
  output logic [31:0]         push_data_o
);
  logic [31:0] cand;
  logic        cand_v, par_ok, sdi_ok, lbl_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand   <= '0;
      cand_v <= 1'b0;
    end else begin
      cand_v <= word_v_i;
      if (word_v_i) cand <= word_i;
    end
  end

  // odd parity: xor of all bits is 1
  assign par_ok = ~ctrl_i.par_en | ((^cand) == ~ctrl_i.par_even);
  assign sdi_ok = ~ctrl_i.sdi_en |
                  ((cand[8] == ctrl_i.sdi_b9) && (cand[9] == ctrl_i.sdi_b10));
  assign lbl_ok = ~ctrl_i.lbl_en | label_hit_i;

  assign lbl_o       = cand[7:0];
  assign lbl_vld_o   = cand_v;
  assign push_o      = cand_v & par_ok & sdi_ok & lbl_ok;
  assign push_data_o = cand;

  a_r4_parity_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && ctrl_i.par_en) |-> ((^push_data_o) != ctrl_i.par_even));

  a_r5_sdi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && ctrl_i.sdi_en) |-> (push_data_o[9:8] == {ctrl_i.sdi_b10, ctrl_i.sdi_b9}));

  a_r6_label_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && ctrl_i.lbl_en) |-> label_hit_i);

endmodule

// File: rtl/arinc_rx_fifo.sv
module arinc_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int LEVEL = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [31:0] wdata_i,
  input  logic        pop_i,
  output logic [31:0] head_o,
  output logic        empty_o,
  output logic        level_o,
  output logic        full_o
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign level_o = (cnt >= CW'(LEVEL));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && wr_ptr == $past(wr_ptr)));

  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (empty_o && rd_ptr == $past(rd_ptr)));

  a_r7_push_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> !empty_o);

endmodule

// File: rtl/arinc_rx.sv
module arinc_rx #(
  parameter int CLK_MHZ = 10,
  parameter bit SLOW_50 = 1'b0,
  parameter int DEPTH   = 32,
  parameter int LEVEL   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_a_i,
  input  logic        line_b_i,
  input  logic [1:0]  reg_sel_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [7:0]  wdata_i,
  output logic [31:0] rdata_o,
  output logic [7:0]  lbl_o,
  output logic        lbl_vld_o,
  input  logic        label_hit_i,
  output logic        irq_o
);
  import arinc_rx_pkg::*;

  ctrl_t       ctrl_q;
  logic        word_v, push, pop, f_empty, f_level, f_full;
  logic [31:0] word, push_data, head, last_q;
  reg_sel_e    sel;

  assign sel = reg_sel_e'(reg_sel_i);
  assign pop = rd_en_i && (sel == SEL_DATA);

  arinc_rx_line #(.CLK_MHZ(CLK_MHZ), .SLOW_50(SLOW_50)) u_line (
    .clk_i, .rst_ni,
    .a_i      (line_a_i),
    .b_i      (line_b_i),
    .slow_i   (ctrl_q.slow),
    .word_v_o (word_v),
    .word_o   (word)
  );

  arinc_rx_filter u_filt (
    .clk_i, .rst_ni,
    .word_v_i    (word_v),
    .word_i      (word),
    .ctrl_i      (ctrl_q),
    .label_hit_i (label_hit_i),
    .lbl_o       (lbl_o),
    .lbl_vld_o   (lbl_vld_o),
    .push_o      (push),
    .push_data_o (push_data)
  );

  arinc_rx_fifo #(.DEPTH(DEPTH), .LEVEL(LEVEL)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .wdata_i (push_data),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (f_empty),
    .level_o (f_level),
    .full_o  (f_full)
  );

  assign irq_o = f_empty | f_level | f_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rdata_o <= '0;
      last_q  <= '0;
    end else begin
      if (wr_en_i && sel == SEL_CTRL) ctrl_q <= ctrl_t'({1'b0, wdata_i[6:0]});
      if (rd_en_i) begin
        case (sel)
          SEL_DATA: begin
            if (!f_empty) begin
              rdata_o <= head;
              last_q  <= head;
            end else begin
              rdata_o <= last_q;
            end
          end
          SEL_CTRL: rdata_o <= {24'd0, ctrl_q};
          SEL_STAT: rdata_o <= {29'd0, f_full, f_level, f_empty};
          default:  rdata_o <= '0;
        endcase
      end
    end
  end

  a_r10_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel == SEL_CTRL) |=> $stable(ctrl_q));

  a_r10_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.spare == 1'b0);

endmodule

// File: tb/sim_arinc_rx.sv
`timescale 1ns/1ps
module sim_arinc_rx;
  localparam int CLK_MHZ = 1;
  localparam int DEPTH   = 4;
  localparam int LEVEL   = 2;
  localparam int FAST    = CLK_MHZ * 10;
  localparam int SLOW    = CLK_MHZ * 80;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        la = 1'b0, lb = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  lbl;
  logic        lbl_vld, hit, irq;

  bit          hit_tab [256];
  logic [31:0] q [$];
  logic [31:0] last_rd = '0;
  logic [7:0]  ctrl_m = '0;
  bit          cmp_on = 1'b0;
  bit          finished = 1'b0;
  int          nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  always_comb hit = hit_tab[lbl];

  arinc_rx #(.CLK_MHZ(CLK_MHZ), .SLOW_50(1'b0), .DEPTH(DEPTH), .LEVEL(LEVEL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_a_i(la), .line_b_i(lb),
    .reg_sel_i(sel), .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .lbl_o(lbl), .lbl_vld_o(lbl_vld), .label_hit_i(hit),
    .irq_o(irq)
  );

  function automatic logic [2:0] stat_m();
    return {q.size() == DEPTH, q.size() >= LEVEL, q.size() == 0};
  endfunction

  function automatic bit accept_m(logic [31:0] w);
    bit ok = 1'b1;
    if (ctrl_m[2] && (($countones(w) % 2 == 1) == ctrl_m[3])) ok = 1'b0;
    if (ctrl_m[4] && (w[8] != ctrl_m[5] || w[9] != ctrl_m[6])) ok = 1'b0;
    if (ctrl_m[1] && !hit_tab[w[7:0]]) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // every-clock comparison of the interrupt against the model (R7)
  always @(posedge clk) begin
    #8;
    if (cmp_on && !finished) check(irq == (|stat_m()), "R7 irq", {31'd0, irq}, {31'd0, |stat_m()});
  end

  task automatic send_bit(bit v, int cyc);
    la = v; lb = ~v;
    repeat (cyc / 2) @(negedge clk);
    la = 1'b0; lb = 1'b0;
    repeat (cyc - cyc / 2) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] w, int nbits, int cyc);
    for (int k = 0; k < nbits; k++) begin
      bit v;
      if (k < 8) v = w[7-k];
      else if (k < 32) v = w[k];
      else v = 1'b1;
      send_bit(v, cyc);
    end
  endtask

  // full word plus idle; model updated once the gap has run out
  task automatic tx_word(logic [31:0] w, int nbits, int cyc, int gap_cyc);
    @(negedge clk);
    cmp_on = 1'b0;
    send_bits(w, nbits, cyc);
    repeat (6 * gap_cyc) @(negedge clk);
    if (nbits == 32 && accept_m(w) && q.size() < DEPTH) q.push_back(w);
    cmp_on = 1'b1;
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    @(negedge clk);
    sel = 2'b01; wdata = v; wr_en = 1'b1;
    ctrl_m = {1'b0, v[6:0]};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] s, output logic [31:0] got);
    @(negedge clk);
    sel = s; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    got = rdata;
  endtask

  task automatic rd_data_chk(string req);
    logic [31:0] exp, got;
    @(negedge clk);
    sel = 2'b00; rd_en = 1'b1;
    if (q.size() > 0) begin
      exp = q.pop_front();
      last_rd = exp;
    end else exp = last_rd;
    @(negedge clk);
    rd_en = 1'b0;
    got = rdata;
    check(got == exp, req, got, exp);
  endtask

  task automatic stat_chk(string req);
    logic [31:0] got;
    rd_reg(2'b10, got);
    check(got == {29'd0, stat_m()}, req, got, {29'd0, stat_m()});
  endtask

  task automatic drain(string req);
    while (q.size() > 0) rd_data_chk(req);
    stat_chk(req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // reset state: R10 control zero, R7 empty only, R9 empty read gives zero
    rd_reg(2'b01, got);
    check(got == 32'd0, "R10 ctrl reset", got, 32'd0);
    stat_chk("R7 reset status");
    rd_data_chk("R9 empty read after reset");

    // R1 / R11: label reversal and bit order
    tx_word(32'hA5C3_0F61, 32, FAST, FAST);
    stat_chk("R7 one word");
    rd_data_chk("R1 word order");
    tx_word(32'h1234_5680, 32, FAST, FAST);
    rd_data_chk("R11 bit decode");
    stat_chk("R7 empty again");

    // R2: short and long words, and too short a gap
    tx_word(32'hDEAD_BEEF, 31, FAST, FAST);
    stat_chk("R2 31 bits discarded");
    tx_word(32'hDEAD_BEEF, 33, FAST, FAST);
    stat_chk("R2 33 bits discarded");
    @(negedge clk);
    cmp_on = 1'b0;
    send_bits(32'h0BAD_0001, 32, FAST);
    repeat (2 * FAST) @(negedge clk);
    tx_word(32'h0BAD_0002, 32, FAST, FAST);
    q.delete();
    stat_chk("R2 short gap discards both");
    tx_word(32'h7777_0011, 32, FAST, FAST);
    rd_data_chk("R2 good word after bad");

    // R4: parity
    wr_ctrl(8'h04);
    tx_word(32'h0000_0001, 32, FAST, FAST);
    tx_word(32'h0000_0003, 32, FAST, FAST);
    drain("R4 odd parity");
    wr_ctrl(8'h0C);
    tx_word(32'h0000_0001, 32, FAST, FAST);
    tx_word(32'h0000_0003, 32, FAST, FAST);
    drain("R4 even parity");
    wr_ctrl(8'h00);
    tx_word(32'h8000_0003, 32, FAST, FAST);
    drain("R4 bit 31 as data");

    // R5: SDI filter, expect bit8=1 bit9=0
    wr_ctrl(8'h30);
    tx_word(32'h0000_0155, 32, FAST, FAST);
    tx_word(32'h0000_0255, 32, FAST, FAST);
    tx_word(32'h0000_0355, 32, FAST, FAST);
    drain("R5 sdi match");

    // R6: external label match
    hit_tab[8'h3A] = 1'b1;
    wr_ctrl(8'h02);
    tx_word(32'h0010_003A, 32, FAST, FAST);
    tx_word(32'h0010_003B, 32, FAST, FAST);
    drain("R6 label filter");
    wr_ctrl(8'h00);
    tx_word(32'h0010_003B, 32, FAST, FAST);
    drain("R6 label ignored when off");

    // R3: slow cells break up at the fast rate, decode at the slow rate
    tx_word(32'h5A5A_1234, 32, 100, FAST);
    q.delete();
    stat_chk("R3 slow cells rejected at fast rate");
    wr_ctrl(8'h01);
    tx_word(32'h5A5A_1234, 32, SLOW, SLOW);
    drain("R3 slow rate word");
    wr_ctrl(8'h00);

    // R8 / R9: fill, overflow, ordered pops, empty read repeats last
    tx_word(32'hF000_0001, 32, FAST, FAST);
    tx_word(32'hF000_0002, 32, FAST, FAST);
    stat_chk("R7 at level");
    tx_word(32'hF000_0003, 32, FAST, FAST);
    tx_word(32'hF000_0004, 32, FAST, FAST);
    tx_word(32'hF000_0005, 32, FAST, FAST);
    stat_chk("R8 full after overflow");
    rd_data_chk("R8 oldest kept");
    rd_data_chk("R9 pop order");
    stat_chk("R7 level after pops");
    rd_data_chk("R9 pop order");
    rd_data_chk("R8 last stored not overwritten");
    stat_chk("R7 empty after drain");
    rd_data_chk("R9 empty read returns last");
    stat_chk("R9 empty read changes nothing");

    // R10: spare bit and reserved select
    wr_ctrl(8'hFF);
    rd_reg(2'b01, got);
    check(got == 32'h7F, "R10 ctrl spare reads zero", got, 32'h7F);
    rd_reg(2'b11, got);
    check(got == 32'd0, "R10 reserved select", got, 32'd0);
    wr_ctrl(8'h00);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule